// File: doc/BRIEF.md
# Oscillator Warm-Up Timer

This block holds back the use of a high-speed oscillator until it has had time to settle. It counts ticks of a selectable oscillator, internal or external, up to a programmed terminal count and then raises a done flag. The oscillator's ticks arrive as single-cycle enables that are already synchronised to the system clock. The block does not model the oscillator itself.

Software programs a 12-bit period field that becomes bits [15:4] of a 16-bit terminal count; the low four bits are always zero. It also picks the counted source and starts a run with a strobe. The power-mode controller can start the same run with a hardware request when the chip wakes from deep stop. Software that waits on the internal oscillator should poll the done flag of this block, not a ready indication from the oscillator.

Top module: `osc_warmup_timer`

## Requirements
- R1: While and after reset, the period readback is 0x800, the source readback is 0 (internal), and busy and done are both 0.
- R2: A cycle with `cfg_we` high stores `cfg_period` and `cfg_ext_sel`. Both readbacks show the new values from the next cycle onward.
- R3: When `sw_start` is sampled high and no run is in progress, busy is 1 and done is 0 from the next cycle.
- R4: A run ends after T ticks of its source, where T is the stored period times 16, and a period of 0 means T = 65536. The tick that starts the run's cycle is not counted. Busy falls and done rises in the cycle after the edge that samples the T-th tick.
- R5: Only the source selected when the run starts is counted (`cfg_ext_sel` 1 = `tick_ext`, 0 = `tick_int`). Ticks on the other input have no effect.
- R6: `hw_start` starts a run exactly like `sw_start`.
- R7: `sw_start` and `hw_start` high in the same cycle produce one run of length T, with no second run after it.
- R8: A configuration write during a run updates the readbacks at once. It changes neither the length nor the source of that run and applies from the next start.
- R9: A start request of either kind while busy is 1 is ignored, and the run in progress keeps its original end point.
- R10: Once a run ends, done stays 1 and busy stays 0 until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_period | input | 12 | Period field, bits [15:4] of the terminal count |
| cfg_ext_sel | input | 1 | Counted source: 1 external, 0 internal |
| sw_start | input | 1 | Software start strobe |
| hw_start | input | 1 | Start request on wake from deep stop |
| tick_int | input | 1 | Synchronised tick enable of the internal oscillator |
| tick_ext | input | 1 | Synchronised tick enable of the external oscillator |
| busy | output | 1 | Warm-up run in progress (start bit readback) |
| done | output | 1 | Last run has completed |
| period_rd | output | 12 | Stored period field |
| ext_sel_rd | output | 1 | Stored source select |

## Verification
The assertions assume that the tick inputs are already synchronous to `clk` and are sampled like any other input. They also assume that reset is held for at least one edge before any stimulus. The bench drives every input on the falling edge, holds the first reset for several cycles, and re-applies reset only between runs. Tick patterns cover steady, every-third-cycle, pseudo-random and silent inputs. Starts are pulsed for single cycles, apart from the deliberate collisions of R7 and R9.

// File: rtl/owt_pkg.sv
package owt_pkg;

    localparam int PROG_W = 12;
    localparam int LOW_W  = 4;
    localparam int CNT_W  = PROG_W + LOW_W;
    localparam int NSRC   = 2;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    typedef struct packed {
        logic [PROG_W-1:0] period;
        src_e              src;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] term;
        src_e             src;
    } run_t;

    // Terminal count: programmed field on top, fixed zeros below.
    function automatic logic [CNT_W-1:0] term_of(input logic [PROG_W-1:0] p);
        return {p, {LOW_W{1'b0}}};
    endfunction

endpackage

// File: rtl/owt_cfg_reg.sv
module owt_cfg_reg
    import owt_pkg::*;
#(
    parameter logic [PROG_W-1:0] RESET_PERIOD = 12'h800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PROG_W-1:0] wperiod,
    input  logic              wsrc,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.period <= RESET_PERIOD;
            cfg.src    <= SRC_INT;
        end else if (we) begin
            cfg.period <= wperiod;
            cfg.src    <= src_e'(wsrc);
        end
    end

endmodule

// File: rtl/owt_tick_sel.sv
module owt_tick_sel
    import owt_pkg::*;
(
    input  logic [NSRC-1:0] ticks,
    input  src_e            src,
    output logic            tick
);

    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = ticks[g] && (int'(src) == g);
    end

    assign tick = |hit;

endmodule

// File: rtl/owt_run_ctl.sv
module owt_run_ctl
    import owt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    input  cfg_t cfg,
    input  logic tick,
    output src_e run_src,
    output logic busy,
    output logic done
);

    run_t             run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             accept;
    logic             finish;

    assign accept  = start_req && !busy;
    assign cnt_nxt = cnt_q + 1'b1;
    assign finish  = busy && tick && (cnt_nxt == run_q.term);
    assign run_src = run_q.src;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '{term: '0, src: SRC_INT};
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (accept) begin
            run_q <= '{term: term_of(cfg.period), src: cfg.src};
            cnt_q <= '0;
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy && tick) begin
            cnt_q <= cnt_nxt;
            if (finish) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/osc_warmup_timer.sv
module osc_warmup_timer
    import owt_pkg::*;
#(
    parameter logic [PROG_W-1:0] RESET_PERIOD = 12'h800
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [PROG_W-1:0] cfg_period,
    input  logic              cfg_ext_sel,
    input  logic              sw_start,
    input  logic              hw_start,
    input  logic              tick_int,
    input  logic              tick_ext,
    output logic              busy,
    output logic              done,
    output logic [PROG_W-1:0] period_rd,
    output logic              ext_sel_rd
);

    cfg_t            cfg;
    src_e            run_src;
    logic            tick_sel;
    logic [NSRC-1:0] ticks;

    assign ticks[SRC_INT] = tick_int;
    assign ticks[SRC_EXT] = tick_ext;

    owt_cfg_reg #(.RESET_PERIOD(RESET_PERIOD)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wperiod (cfg_period),
        .wsrc    (cfg_ext_sel),
        .cfg     (cfg)
    );

    owt_tick_sel u_sel (
        .ticks (ticks),
        .src   (run_src),
        .tick  (tick_sel)
    );

    owt_run_ctl u_run (
        .clk       (clk),
        .rst       (rst),
        .start_req (sw_start || hw_start),
        .cfg       (cfg),
        .tick      (tick_sel),
        .run_src   (run_src),
        .busy      (busy),
        .done      (done)
    );

    assign period_rd  = cfg.period;
    assign ext_sel_rd = cfg.src;

endmodule

// File: rtl/owt_checker.sv
module owt_checker #(
    parameter logic [11:0] RESET_PERIOD = 12'h800
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [11:0] cfg_period,
    input logic        cfg_ext_sel,
    input logic        sw_start,
    input logic        hw_start,
    input logic        tick_int,
    input logic        tick_ext,
    input logic        busy,
    input logic        done,
    input logic [11:0] period_rd,
    input logic        ext_sel_rd
);

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && !done && period_rd == RESET_PERIOD && !ext_sel_rd));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (period_rd == $past(cfg_period) && ext_sel_rd == $past(cfg_ext_sel)));

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy && (sw_start || hw_start)) |=> (busy && !done));

    a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r5_end_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_int && !tick_ext) |=> busy);

    a_r10_done_holds: assert property (@(posedge clk) disable iff (rst)
        (done && !sw_start && !hw_start) |=> (done && !busy));

endmodule

bind osc_warmup_timer owt_checker #(.RESET_PERIOD(RESET_PERIOD)) u_owt_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_period  (cfg_period),
    .cfg_ext_sel (cfg_ext_sel),
    .sw_start    (sw_start),
    .hw_start    (hw_start),
    .tick_int    (tick_int),
    .tick_ext    (tick_ext),
    .busy        (busy),
    .done        (done),
    .period_rd   (period_rd),
    .ext_sel_rd  (ext_sel_rd)
);

// File: tb/tb_osc_warmup_timer.sv
module tb_osc_warmup_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_period = '0;
    logic        cfg_ext_sel = 1'b0;
    logic        sw_start = 1'b0;
    logic        hw_start = 1'b0;
    logic        tick_int = 1'b0;
    logic        tick_ext = 1'b0;
    logic        busy, done, ext_sel_rd;
    logic [11:0] period_rd;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    int    int_mode = 0;
    int    ext_mode = 0;
    bit    compare_on = 1'b0;
    bit    finished = 1'b0;
    string tag = "R1";
    logic [7:0] lfsr = 8'hA5;

    // reference model state
    int m_period, m_src, m_busy, m_done, m_cnt, m_term, m_rsrc;

    always #10 clk = ~clk;  // 50 MHz

    osc_warmup_timer dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_period(cfg_period),
        .cfg_ext_sel(cfg_ext_sel), .sw_start(sw_start), .hw_start(hw_start),
        .tick_int(tick_int), .tick_ext(tick_ext), .busy(busy), .done(done),
        .period_rd(period_rd), .ext_sel_rd(ext_sel_rd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // Behavioural model, evaluated on every rising edge.
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_period = 12'h800; m_src = 0; m_busy = 0; m_done = 0;
            m_cnt = 0; m_term = 0; m_rsrc = 0;
        end else begin
            if (m_busy != 0) begin
                if ((m_rsrc != 0) ? tick_ext : tick_int) begin
                    m_cnt++;
                    if (m_cnt == m_term) begin m_busy = 0; m_done = 1; end
                end
            end else if (sw_start || hw_start) begin
                m_busy = 1; m_done = 0; m_cnt = 0;
                m_term = (m_period == 0) ? 65536 : m_period * 16;
                m_rsrc = m_src;
            end
            if (cfg_we) begin m_period = cfg_period; m_src = cfg_ext_sel; end
        end
        compare_on = 1'b1;
    end

    function automatic bit gen_tick(input int mode);
        case (mode)
            1: return 1'b1;
            2: return (cyc % 3) == 0;
            3: return lfsr[0];
            default: return 1'b0;
        endcase
    endfunction

    // Compare on the falling edge, then drive the tick inputs.
    always @(negedge clk) begin
        if (compare_on) begin
            check({tag, " busy"}, busy, m_busy);
            check({tag, " done"}, done, m_done);
            check("R2 period", period_rd, m_period);
            check("R2 source", ext_sel_rd, m_src);
        end
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick_int = gen_tick(int_mode);
        tick_ext = gen_tick(ext_mode);
    end

    task automatic write_cfg(input logic [11:0] p, input logic s);
        @(negedge clk);
        cfg_we = 1'b1; cfg_period = p; cfg_ext_sel = s;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input bit sw, input bit hw);
        @(negedge clk);
        sw_start = sw; hw_start = hw;
        @(negedge clk);
        sw_start = 1'b0; hw_start = 1'b0;
    endtask

    // Pulse a start and count falling edges until done rises.
    task automatic start_measure(input bit sw, input bit hw, output int n);
        @(negedge clk);
        sw_start = sw; hw_start = hw;
        n = 0;
        @(negedge clk);
        sw_start = 1'b0; hw_start = 1'b0;
        n = 1;
        while (!done && n < 70000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 70000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        tag = "R1";
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 period", period_rd, 12'h800);
        check("R1 source", ext_sel_rd, 0);
        rst = 1'b0;

        // R2: configuration write and readback
        write_cfg(12'h001, 1'b0);
        check("R2 period readback", period_rd, 1);
        check("R2 source readback", ext_sel_rd, 0);

        // R3 + R4: software start, steady internal ticks, T = 16
        tag = "R4"; int_mode = 1;
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        check("R3 busy after start", busy, 1);
        check("R3 done cleared", done, 0);
        n = 1;
        while (!done && n < 100) begin @(negedge clk); n++; end
        check("R4 run length 16 ticks", n, 17);

        // R5: external source, only internal ticks present
        tag = "R5";
        write_cfg(12'h002, 1'b1);
        int_mode = 1; ext_mode = 0;
        pulse(1, 0);
        repeat (60) @(negedge clk);
        check("R5 other source ignored", busy, 1);
        ext_mode = 2;
        wait_idle();
        check("R5 run ends on selected ticks", done, 1);

        // R6: hardware start, pseudo-random external ticks
        tag = "R6"; ext_mode = 3;
        pulse(0, 1);
        check("R6 hw start busy", busy, 1);
        wait_idle();
        check("R6 hw run done", done, 1);

        // R7: both starts together, one run only
        tag = "R7";
        write_cfg(12'h001, 1'b0);
        int_mode = 1; ext_mode = 0;
        start_measure(1, 1, n);
        check("R7 single run length", n, 17);
        repeat (20) @(negedge clk);
        check("R7 no second run", busy, 0);

        // R8: write during run, affects only next run
        tag = "R8";
        write_cfg(12'h002, 1'b0);
        pulse(1, 0);
        repeat (5) @(negedge clk);
        write_cfg(12'h001, 1'b1);
        check("R8 readback updated", period_rd, 1);
        n = 8;
        while (!done && n < 100) begin @(negedge clk); n++; end
        check("R8 run keeps old length", n, 33);
        ext_mode = 1; int_mode = 0;
        start_measure(1, 0, n);
        check("R8 next run uses new value", n, 17);

        // R9: start while busy ignored
        tag = "R9";
        write_cfg(12'h002, 1'b0);
        int_mode = 1; ext_mode = 0;
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        n = 1;
        repeat (10) begin @(negedge clk); n++; end
        sw_start = 1'b1; hw_start = 1'b1;
        @(negedge clk);
        n++;
        sw_start = 1'b0; hw_start = 1'b0;
        while (!done && n < 100) begin @(negedge clk); n++; end
        check("R9 end point unchanged", n, 33);

        // R10: done holds
        tag = "R10"; int_mode = 3;
        repeat (30) @(negedge clk);
        check("R10 done held", done, 1);
        check("R10 busy low", busy, 0);

        // R4: period 0 means 65536 ticks
        tag = "R4";
        write_cfg(12'h000, 1'b0);
        int_mode = 1;
        start_measure(1, 0, n);
        check("R4 zero period length", n, 65537);

        // R1: reset value 0x800 gives 32768 ticks
        tag = "R1";
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 done after reset", done, 0);
        rst = 1'b0;
        start_measure(0, 1, n);
        check("R1 default period length", n, 32769);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule